// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block turns a group of four decoded instructions into physical-register form in a single clock. Each instruction carries one destination and two source architectural register numbers. Source numbers are looked up in a mapping table. Each destination receives a fresh physical register taken from a circular pool of free registers. When an instruction reads or overwrites a register that an earlier instruction in the same group writes, it is steered to that earlier instruction's new register within the same cycle. For every destination, the register it displaces is also reported, so the retirement side can hand it back later.

Every accepted group gets a small rolling stamp. Under that stamp the block saves the mapping table as it stood before the group and the pool's read pointer. A recovery request names a stamp. In one cycle it puts back both saved values, which undoes that group and every younger one. Retired registers come back through a four-lane release port. That port keeps working during renaming and during recovery.

Top module: `rename4`

## Requirements
- R1: An accepted group (in_valid and in_ready high at a rising edge) shows on the outputs from the next edge with out_valid high for exactly one cycle. Lane k's destination is the k-th register taken from the pool, lane 0 first, and the four destinations are distinct.
- R2: A source with no earlier writer in its group gets the physical register currently mapped to its architectural register.
- R3: A source that an earlier lane of the same group writes gets the new register of the nearest such earlier lane. A lane's own destination does not feed its own sources.
- R4: When several lanes of a group write one architectural register, the table keeps the youngest (highest lane) writer. Each lane's out_old_dst is the mapping that lane displaces, including a new register from an earlier lane.
- R5: After reset, architectural register i maps to physical register i, the pool holds 32 to 79 in ascending order, in_ready is 1, out_valid is 0, and the first group gets stamp 0.
- R6: in_ready is low while fewer than four registers are free. No partial group is renamed and nothing is taken from the pool while the group waits.
- R7: Stamps are handed out in order, modulo 8, one per accepted group, and appear on out_stamp.
- R8: A recover cycle holds in_ready low. It restores the table and the pool read pointer saved for recover_stamp, and the next group is stamped recover_stamp.
- R9: Release lanes with rel_valid set append their registers to the pool in lane order. This happens in the same cycle as a rename, without disturbing the rename.
- R10: A release in the same cycle as a recovery still reaches the pool after the restored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A group is presented |
| in_ready | output | 1 | The group will be taken at this edge |
| in_dst | input | 4x5 | Destination architectural register per lane |
| in_src_a | input | 4x5 | First source per lane |
| in_src_b | input | 4x5 | Second source per lane |
| out_valid | output | 1 | Renamed group present this cycle |
| out_stamp | output | 3 | Stamp given to the group |
| out_dst | output | 4x7 | New physical destination per lane |
| out_src_a | output | 4x7 | Physical first source per lane |
| out_src_b | output | 4x7 | Physical second source per lane |
| out_old_dst | output | 4x7 | Displaced physical register per lane |
| rel_valid | input | 4 | Release lane enables |
| rel_preg | input | 4x7 | Registers returned to the pool |
| recover | input | 1 | Roll back to a saved stamp |
| recover_stamp | input | 3 | Stamp to roll back to |

## Verification
The release port can fire in the same cycle as a rename and in the same cycle as a recovery, and both overlaps are provoked on purpose. In the first, the pool is drained to exactly four free entries and two registers are released while a group is taken. The group must get the four older entries, and the two new ones must surface in the following group. In the second, a release coincides with a rollback. The restored read pointer must first hand out the reclaimed entries, and once those and the stale entries behind them are used up, the register released during the rollback must come out next.

// File: rtl/rename_pkg.sv
package rename_pkg;
    localparam int NUM_ARCH      = 32;
    localparam int NUM_PHYS      = 80;
    localparam int GROUP         = 4;
    localparam int NUM_STAMPS    = 8;

    localparam int AW            = $clog2(NUM_ARCH);
    localparam int PW            = $clog2(NUM_PHYS);
    localparam int SW            = $clog2(NUM_STAMPS);
    localparam int FL_DEPTH      = 1 << $clog2(NUM_PHYS);
    localparam int FLW           = $clog2(FL_DEPTH);
    localparam int NUM_FREE_INIT = NUM_PHYS - NUM_ARCH;
    localparam int RD_PORTS      = 3 * GROUP;

    typedef logic [AW-1:0] arch_t;
    typedef logic [PW-1:0] preg_t;
    typedef logic [SW-1:0] stamp_t;
    typedef logic [FLW:0]  flptr_t;   // one extra bit separates full from empty

    typedef struct packed {
        arch_t dst;
        arch_t src_a;
        arch_t src_b;
    } uop_t;

    typedef struct packed {
        preg_t dst;
        preg_t src_a;
        preg_t src_b;
        preg_t old_dst;
    } ren_t;

    // Number of set lanes strictly below 'lane'
    function automatic flptr_t lanes_below(input logic [GROUP-1:0] v, input int lane);
        flptr_t n;
        n = '0;
        for (int i = 0; i < GROUP; i++) begin
            if (i < lane && v[i]) n = n + flptr_t'(1);
        end
        return n;
    endfunction
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list
    import rename_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic             snap_we,
    input  stamp_t           snap_idx,
    input  logic             restore,
    input  stamp_t           restore_idx,
    input  logic [GROUP-1:0] rel_valid,
    input  preg_t            rel_preg [GROUP],
    output preg_t            pop_preg [GROUP],
    output flptr_t           free_cnt
);
    preg_t  mem_q      [FL_DEPTH];
    flptr_t head_q;
    flptr_t tail_q;
    flptr_t head_snap_q [NUM_STAMPS];
    flptr_t rel_slot   [GROUP];
    flptr_t rel_total;

    always_comb begin
        for (int i = 0; i < GROUP; i++) begin
            rel_slot[i] = tail_q + lanes_below(rel_valid, i);
        end
        rel_total = lanes_below(rel_valid, GROUP);
    end

    always_comb begin
        for (int i = 0; i < GROUP; i++) begin
            flptr_t p;
            p = head_q + flptr_t'(i);
            pop_preg[i] = mem_q[p[FLW-1:0]];
        end
    end

    assign free_cnt = tail_q - head_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FL_DEPTH; i++) begin
                mem_q[i] <= (i < NUM_FREE_INIT) ? preg_t'(NUM_ARCH + i) : '0;
            end
            for (int s = 0; s < NUM_STAMPS; s++) begin
                head_snap_q[s] <= '0;
            end
            head_q <= '0;
            tail_q <= flptr_t'(NUM_FREE_INIT);
        end else begin
            for (int i = 0; i < GROUP; i++) begin
                if (rel_valid[i]) mem_q[rel_slot[i][FLW-1:0]] <= rel_preg[i];
            end
            tail_q <= tail_q + rel_total;
            if (restore)    head_q <= head_snap_q[restore_idx];
            else if (alloc) head_q <= head_q + flptr_t'(GROUP);
            if (snap_we)    head_snap_q[snap_idx] <= head_q;
        end
    end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
    import rename_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  arch_t  wr_arch [GROUP],
    input  preg_t  wr_preg [GROUP],
    input  logic   snap_we,
    input  stamp_t snap_idx,
    input  logic   restore,
    input  stamp_t restore_idx,
    input  arch_t  rd_arch [RD_PORTS],
    output preg_t  rd_preg [RD_PORTS]
);
    preg_t map_q  [NUM_ARCH];
    preg_t snap_q [NUM_STAMPS][NUM_ARCH];

    always_comb begin
        for (int p = 0; p < RD_PORTS; p++) begin
            rd_preg[p] = map_q[rd_arch[p]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < NUM_ARCH; a++) begin
                map_q[a] <= preg_t'(a);
            end
            for (int s = 0; s < NUM_STAMPS; s++) begin
                for (int a = 0; a < NUM_ARCH; a++) begin
                    snap_q[s][a] <= preg_t'(a);
                end
            end
        end else begin
            if (restore) begin
                for (int a = 0; a < NUM_ARCH; a++) begin
                    map_q[a] <= snap_q[restore_idx][a];
                end
            end else if (wr_en) begin
                // later lanes override earlier ones: youngest writer stays
                for (int i = 0; i < GROUP; i++) begin
                    map_q[wr_arch[i]] <= wr_preg[i];
                end
            end
            if (snap_we) begin
                for (int a = 0; a < NUM_ARCH; a++) begin
                    snap_q[snap_idx][a] <= map_q[a];
                end
            end
        end
    end
endmodule

// File: rtl/rn_group_resolve.sv
module rn_group_resolve
    import rename_pkg::*;
(
    input  uop_t  uop       [GROUP],
    input  preg_t new_preg  [GROUP],
    input  preg_t map_src_a [GROUP],
    input  preg_t map_src_b [GROUP],
    input  preg_t map_old   [GROUP],
    output ren_t  ren       [GROUP]
);
    always_comb begin
        for (int i = 0; i < GROUP; i++) begin
            ren[i].dst     = new_preg[i];
            ren[i].src_a   = map_src_a[i];
            ren[i].src_b   = map_src_b[i];
            ren[i].old_dst = map_old[i];
            // scan older lanes; the nearest match is applied last
            for (int j = 0; j < GROUP; j++) begin
                if (j < i) begin
                    if (uop[j].dst == uop[i].src_a) ren[i].src_a   = new_preg[j];
                    if (uop[j].dst == uop[i].src_b) ren[i].src_b   = new_preg[j];
                    if (uop[j].dst == uop[i].dst)   ren[i].old_dst = new_preg[j];
                end
            end
        end
    end
endmodule

// File: rtl/rename4.sv
module rename4
    import rename_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [GROUP-1:0][AW-1:0]  in_dst,
    input  logic [GROUP-1:0][AW-1:0]  in_src_a,
    input  logic [GROUP-1:0][AW-1:0]  in_src_b,
    output logic                      out_valid,
    output logic [SW-1:0]             out_stamp,
    output logic [GROUP-1:0][PW-1:0]  out_dst,
    output logic [GROUP-1:0][PW-1:0]  out_src_a,
    output logic [GROUP-1:0][PW-1:0]  out_src_b,
    output logic [GROUP-1:0][PW-1:0]  out_old_dst,
    input  logic [GROUP-1:0]          rel_valid,
    input  logic [GROUP-1:0][PW-1:0]  rel_preg,
    input  logic                      recover,
    input  logic [SW-1:0]             recover_stamp
);
    uop_t   uop      [GROUP];
    preg_t  rel_arr  [GROUP];
    arch_t  wr_arch  [GROUP];
    arch_t  rd_arch  [RD_PORTS];
    preg_t  rd_preg  [RD_PORTS];
    preg_t  new_preg [GROUP];
    preg_t  m_a      [GROUP];
    preg_t  m_b      [GROUP];
    preg_t  m_o      [GROUP];
    ren_t   ren      [GROUP];
    flptr_t free_cnt;
    stamp_t stamp_q;
    logic   accept;

    assign in_ready = !recover && (free_cnt >= flptr_t'(GROUP));
    assign accept   = in_valid && in_ready;

    for (genvar g = 0; g < GROUP; g++) begin : g_lane
        assign uop[g]                 = '{dst: in_dst[g], src_a: in_src_a[g], src_b: in_src_b[g]};
        assign wr_arch[g]             = in_dst[g];
        assign rel_arr[g]             = rel_preg[g];
        assign rd_arch[g]             = in_src_a[g];
        assign rd_arch[GROUP + g]     = in_src_b[g];
        assign rd_arch[2 * GROUP + g] = in_dst[g];
        assign m_a[g]                 = rd_preg[g];
        assign m_b[g]                 = rd_preg[GROUP + g];
        assign m_o[g]                 = rd_preg[2 * GROUP + g];
    end

    rn_free_list u_free (
        .clk        (clk),
        .rst        (rst),
        .alloc      (accept),
        .snap_we    (accept),
        .snap_idx   (stamp_q),
        .restore    (recover),
        .restore_idx(recover_stamp),
        .rel_valid  (rel_valid),
        .rel_preg   (rel_arr),
        .pop_preg   (new_preg),
        .free_cnt   (free_cnt)
    );

    rn_map_table u_map (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (accept),
        .wr_arch    (wr_arch),
        .wr_preg    (new_preg),
        .snap_we    (accept),
        .snap_idx   (stamp_q),
        .restore    (recover),
        .restore_idx(recover_stamp),
        .rd_arch    (rd_arch),
        .rd_preg    (rd_preg)
    );

    rn_group_resolve u_resolve (
        .uop      (uop),
        .new_preg (new_preg),
        .map_src_a(m_a),
        .map_src_b(m_b),
        .map_old  (m_o),
        .ren      (ren)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_stamp   <= '0;
            stamp_q     <= '0;
            out_dst     <= '0;
            out_src_a   <= '0;
            out_src_b   <= '0;
            out_old_dst <= '0;
        end else begin
            out_valid <= accept;
            if (recover)     stamp_q <= recover_stamp;
            else if (accept) stamp_q <= stamp_q + stamp_t'(1);
            if (accept) begin
                out_stamp <= stamp_q;
                for (int g = 0; g < GROUP; g++) begin
                    out_dst[g]     <= ren[g].dst;
                    out_src_a[g]   <= ren[g].src_a;
                    out_src_b[g]   <= ren[g].src_b;
                    out_old_dst[g] <= ren[g].old_dst;
                end
            end
        end
    end
endmodule

// File: rtl/rename4_chk.sv
module rename4_chk
    import rename_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     recover,
    input logic [GROUP-1:0][AW-1:0] in_dst,
    input logic [GROUP-1:0][AW-1:0] in_src_a,
    input logic                     out_valid,
    input logic [GROUP-1:0][PW-1:0] out_dst,
    input logic [GROUP-1:0][PW-1:0] out_src_a,
    input logic [GROUP-1:0][PW-1:0] out_old_dst
);
    AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid); // R1

    AST_NO_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> !out_valid); // R6

    AST_RECOVER_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        recover |-> !in_ready); // R8

    AST_BYPASS_LANE1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(in_dst[0]) == $past(in_src_a[1]))) |-> (out_src_a[1] == out_dst[0])); // R3

    AST_OLD_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(in_dst[0]) == $past(in_dst[1]))) |-> (out_old_dst[1] == out_dst[0])); // R4

    for (genvar i = 0; i < GROUP; i++) begin : g_a
        for (genvar j = i + 1; j < GROUP; j++) begin : g_b
            AST_DST_UNIQUE: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> (out_dst[i] != out_dst[j])); // R1
        end
    end
endmodule

bind rename4 rename4_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .recover    (recover),
    .in_dst     (in_dst),
    .in_src_a   (in_src_a),
    .out_valid  (out_valid),
    .out_dst    (out_dst),
    .out_src_a  (out_src_a),
    .out_old_dst(out_old_dst)
);

// File: tb/rename4_tb.sv
module rename4_tb;
    import rename_pkg::*;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     in_valid = 1'b0;
    logic                     in_ready;
    logic [GROUP-1:0][AW-1:0] in_dst = '0;
    logic [GROUP-1:0][AW-1:0] in_src_a = '0;
    logic [GROUP-1:0][AW-1:0] in_src_b = '0;
    logic                     out_valid;
    logic [SW-1:0]            out_stamp;
    logic [GROUP-1:0][PW-1:0] out_dst;
    logic [GROUP-1:0][PW-1:0] out_src_a;
    logic [GROUP-1:0][PW-1:0] out_src_b;
    logic [GROUP-1:0][PW-1:0] out_old_dst;
    logic [GROUP-1:0]         rel_valid = '0;
    logic [GROUP-1:0][PW-1:0] rel_preg = '0;
    logic                     recover = 1'b0;
    logic [SW-1:0]            recover_stamp = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rename4 u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .out_valid(out_valid), .out_stamp(out_stamp), .out_dst(out_dst),
        .out_src_a(out_src_a), .out_src_b(out_src_b), .out_old_dst(out_old_dst),
        .rel_valid(rel_valid), .rel_preg(rel_preg),
        .recover(recover), .recover_stamp(recover_stamp)
    );

    // per lane: dst, src_a, src_b, expected dst, src_a, src_b, old_dst
    localparam int VEC [3][4][7] = '{
        '{ '{ 1,  2,  3, 32,  2,  3,  1}, '{ 4,  1,  5, 33, 32,  5,  4},
           '{ 1,  4,  1, 34, 33, 32, 32}, '{ 6,  1,  6, 35, 34,  6,  6} },
        '{ '{ 2,  1,  4, 36, 34, 33,  2}, '{ 2,  2,  6, 37, 36, 35, 36},
           '{ 7,  2,  0, 38, 37,  0,  7}, '{ 0,  7,  0, 39, 38,  0,  0} },
        '{ '{31, 31,  1, 40, 31, 34, 31}, '{31, 31,  2, 41, 40, 37, 40},
           '{31, 31,  0, 42, 41, 39, 41}, '{31, 31, 31, 43, 42, 42, 42} }
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_lane(input int l, input int d, input int a, input int b);
        in_dst[l]   = AW'(d);
        in_src_a[l] = AW'(a);
        in_src_b[l] = AW'(b);
    endtask

    task automatic set_rel(input int l, input int p);
        rel_valid[l] = 1'b1;
        rel_preg[l]  = PW'(p);
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        in_valid  = 1'b0;
        rel_valid = '0;
        recover   = 1'b0;
    endtask

    task automatic fire();
        in_valid = 1'b1;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5: reset state
        chk("R5 in_ready after reset", int'(in_ready), 1);
        chk("R5 out_valid after reset", int'(out_valid), 0);

        // table walk: groups A, B, C from the reset mapping
        for (int g = 0; g < 3; g++) begin
            for (int l = 0; l < GROUP; l++) set_lane(l, VEC[g][l][0], VEC[g][l][1], VEC[g][l][2]);
            chk("R6 ready before table group", int'(in_ready), 1);
            fire();
            chk("R1 out_valid", int'(out_valid), 1);
            chk("R7 stamp", int'(out_stamp), g);
            for (int l = 0; l < GROUP; l++) begin
                chk("R1 dst", int'(out_dst[l]), VEC[g][l][3]);
                chk("R3 src_a", int'(out_src_a[l]), VEC[g][l][4]);
                chk("R3 src_b", int'(out_src_b[l]), VEC[g][l][5]);
                chk("R4 old_dst", int'(out_old_dst[l]), VEC[g][l][6]);
            end
            @(negedge clk);
            chk("R1 out_valid single pulse", int'(out_valid), 0);
        end

        // recovery to stamp 1 undoes groups B and C; a group offered meanwhile is refused
        set_lane(0, 5, 5, 5);
        recover = 1'b1;
        recover_stamp = 3'd1;
        in_valid = 1'b1;
        #1;
        chk("R8 in_ready low during recover", int'(in_ready), 0);
        step();
        chk("R8 no output for refused group", int'(out_valid), 0);
        set_lane(0, 3, 2, 7);
        set_lane(1, 5, 31, 1);
        set_lane(2, 8, 0, 4);
        set_lane(3, 9, 6, 3);
        fire();
        chk("R8 stamp reused", int'(out_stamp), 1);
        chk("R8 dst0 from restored pointer", int'(out_dst[0]), 36);
        chk("R8 dst3", int'(out_dst[3]), 39);
        chk("R2 src_a lane0 restored map", int'(out_src_a[0]), 2);
        chk("R2 src_b lane0 restored map", int'(out_src_b[0]), 7);
        chk("R2 src_a lane1 restored map", int'(out_src_a[1]), 31);
        chk("R2 src_b lane1 kept from A", int'(out_src_b[1]), 34);
        chk("R2 src_a lane2", int'(out_src_a[2]), 0);
        chk("R2 src_b lane2", int'(out_src_b[2]), 33);
        chk("R2 src_a lane3", int'(out_src_a[3]), 35);
        chk("R3 src_b lane3 bypass", int'(out_src_b[3]), 36);

        // drain the pool
        n = 0;
        for (int k = 0; k < 20; k++) begin
            if (!in_ready) break;
            for (int l = 0; l < GROUP; l++) set_lane(l, 10 + l, 0, 0);
            fire();
            n++;
        end
        chk("R6 groups until empty", n, 10);
        chk("R6 ready low when empty", int'(in_ready), 0);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R6 stalled group not renamed", int'(out_valid), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R6 still stalled", int'(out_valid), 0);
        in_valid = 1'b0;

        // releases: three lanes, then one more
        set_rel(0, 1);
        set_rel(1, 2);
        set_rel(3, 3);
        step();
        chk("R6 three free is not enough", int'(in_ready), 0);
        set_rel(2, 4);
        step();
        chk("R9 ready after fourth release", int'(in_ready), 1);

        // rename with a concurrent release
        for (int l = 0; l < GROUP; l++) set_lane(l, 20 + l, 0, 0);
        set_rel(0, 5);
        set_rel(1, 6);
        fire();
        chk("R9 dst0 first released", int'(out_dst[0]), 1);
        chk("R9 dst1", int'(out_dst[1]), 2);
        chk("R9 dst2", int'(out_dst[2]), 3);
        chk("R9 dst3", int'(out_dst[3]), 4);
        chk("R7 stamp after wrap", int'(out_stamp), 4);
        chk("R6 two left", int'(in_ready), 0);
        set_rel(2, 7);
        set_rel(3, 8);
        step();
        fire();
        chk("R9 concurrent release dst0", int'(out_dst[0]), 5);
        chk("R9 concurrent release dst3", int'(out_dst[3]), 8);

        // recover to stamp 3 while releasing one register
        set_rel(1, 9);
        recover = 1'b1;
        recover_stamp = 3'd3;
        step();
        for (int l = 0; l < GROUP; l++) set_lane(l, 14 + l, 10 + l, 0);
        fire();
        chk("R8 stamp after second recovery", int'(out_stamp), 3);
        chk("R8 dst0 reclaimed", int'(out_dst[0]), 76);
        chk("R8 dst3 reclaimed", int'(out_dst[3]), 79);
        chk("R8 src_a lane0 snapshot map", int'(out_src_a[0]), 72);
        chk("R8 src_a lane3 snapshot map", int'(out_src_a[3]), 75);
        chk("R8 src_b lane0", int'(out_src_b[0]), 0);
        for (int k = 0; k < 2; k++) begin
            for (int l = 0; l < GROUP; l++) set_lane(l, 10 + l, 0, 0);
            fire();
        end
        chk("R6 one left after rollback", int'(in_ready), 0);
        set_rel(0, 10);
        set_rel(1, 11);
        set_rel(2, 12);
        step();
        chk("R10 ready with release from recover cycle", int'(in_ready), 1);
        for (int l = 0; l < GROUP; l++) set_lane(l, 1 + l, 0, 0);
        fire();
        chk("R10 register released during recovery", int'(out_dst[0]), 9);
        chk("R10 dst1", int'(out_dst[1]), 10);
        chk("R10 dst3", int'(out_dst[3]), 12);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule